// File: doc/BRIEF.md
# Conversion Sequencer for a Sampling Converter

This block is the control state machine that sits in front of a successive-approximation conversion engine. A falling edge on an active-low start strobe launches a conversion. The block raises `busy` for the whole convert phase and sends a one-cycle launch pulse to the engine. It then waits for the engine's done pulse. On the edge that ends the conversion, the engine's result word is captured into the output register. Between conversions the block sits in acquisition and flags `low_pwr`.

Two features set it apart from a plain start/done handshake. First, a running conversion can never be cut short. Neither a fresh strobe edge nor a power-down request can abort it. A power-down request that arrives mid-conversion is stored and honoured only after the result lands. Second, if the strobe is still held low when a conversion ends, the block times an acquisition window of `ACQ_CYC` clocks and then launches the next conversion by itself. It repeats this for as long as the strobe stays low.

The conversion length is set by the engine. The acquisition length is a parameter. The default lengths give a frame of about 100 kSPS at a 250 MHz system clock.

Top module: `conv_seq`

## Requirements
- R1: When no conversion is running and no power-down is requested, a high-to-low change of `start_n` between two clock edges makes `busy` high on the next cycle. In that same cycle `eng_start` is high for exactly one cycle.
- R2: Once `busy` is high it stays high until `eng_done` is sampled high. Further `start_n` edges and `pdn_req` neither end nor restart the conversion, and no second `eng_start` pulse is issued during it.
- R3: `dout` loads `eng_result` on the same edge that drops `busy`. At all other times `dout` holds its value, including when `eng_done` pulses while no conversion is running.
- R4: If `start_n` is low when a conversion completes, `busy` stays low for exactly `ACQ_CYC` cycles and then rises again without any new strobe edge. This repeats while `start_n` stays low.
- R5: If `start_n` is high at completion, or rises during the automatic acquisition, no further conversion happens until a new falling edge. After reset, no conversion happens before the first falling edge.
- R6: `low_pwr` is high whenever `busy` is low and low whenever `busy` is high.
- R7: A synchronous high `rst` gives, on the next cycle, `busy` low, `dout` zero, `pd_active` low, and any stored power-down request discarded.
- R8: A `pdn_req` seen at any time during a conversion, including on the completing edge itself, puts the block into power-down (`pd_active` high) right after completion. This happens even with `start_n` held low.
- R9: While powered down, strobe edges are ignored. `pd_active` drops one cycle after `pdn_req` goes low, and a new falling edge is then needed to start a conversion.
- R10: With no conversion running, a high `pdn_req` gives `pd_active` on the next cycle. It takes precedence over a falling edge that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_n | input | 1 | Conversion start strobe, active low |
| pdn_req | input | 1 | Power-down request, level sensitive |
| eng_done | input | 1 | One-cycle completion pulse from the conversion engine |
| eng_result | input | W | Engine result, valid while eng_done is high |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| busy | output | 1 | High during the convert phase |
| low_pwr | output | 1 | Reduced-power indication, high outside the convert phase |
| pd_active | output | 1 | High while the block is powered down |
| dout | output | W | Result of the most recent completed conversion |

## Verification
The critical collision is between the completion of a conversion and the arrival of a power-down request. Both are decided on the same edge, which also chooses between automatic retriggering and power-down. The bench holds the strobe low, waits until the stub engine raises its done pulse, and raises `pdn_req` in that very cycle. It then expects the result to be latched, `pd_active` to follow, and no new launch despite the low strobe. A second collision is a strobe edge that arrives together with a power-down request while idle. Here power-down must win and no conversion may appear in the scoreboard.

// File: rtl/conv_seq.sv
module conv_seq #(
  parameter int W       = 18,
  parameter int ACQ_CYC = 750
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start_n,
  input  logic         pdn_req,
  input  logic         eng_done,
  input  logic [W-1:0] eng_result,
  output logic         eng_start,
  output logic         busy,
  output logic         low_pwr,
  output logic         pd_active,
  output logic [W-1:0] dout
);
  localparam int CW = $clog2(ACQ_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_CONV, S_ACQ, S_PDN} st_t;

  st_t           st;
  logic          strobe_q;
  logic          pend;
  logic [CW-1:0] acq_cnt;

  wire fall = strobe_q & ~start_n;
  wire halt = pend | pdn_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      strobe_q  <= 1'b1;
      pend      <= 1'b0;
      acq_cnt   <= '0;
      eng_start <= 1'b0;
      dout      <= '0;
    end else begin
      strobe_q  <= start_n;
      eng_start <= 1'b0;
      case (st)
        S_IDLE: begin
          if (pdn_req) st <= S_PDN;
          else if (fall) begin
            st        <= S_CONV;
            eng_start <= 1'b1;
          end
        end
        S_CONV: begin
          if (pdn_req) pend <= 1'b1;
          if (eng_done) begin
            dout <= eng_result;
            pend <= 1'b0;
            if (halt) st <= S_PDN;
            else if (!start_n) begin
              st      <= S_ACQ;
              acq_cnt <= '0;
            end else st <= S_IDLE;
          end
        end
        S_ACQ: begin
          if (pdn_req) st <= S_PDN;
          else if (start_n) st <= S_IDLE;
          else if (acq_cnt == CW'(ACQ_CYC - 1)) begin
            st        <= S_CONV;
            eng_start <= 1'b1;
          end else acq_cnt <= acq_cnt + 1'b1;
        end
        default: begin
          if (!pdn_req) st <= S_IDLE;
        end
      endcase
    end
  end

  assign busy      = (st == S_CONV);
  assign low_pwr   = ~busy;
  assign pd_active = (st == S_PDN);
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         start_n,
  input logic         pdn_req,
  input logic         eng_done,
  input logic [W-1:0] eng_result,
  input logic         eng_start,
  input logic         busy,
  input logic         low_pwr,
  input logic         pd_active,
  input logic [W-1:0] dout
);
  logic seen_hi;
  always_ff @(posedge clk) begin
    if (rst) seen_hi <= 1'b1;
    else     seen_hi <= start_n;
  end

  // R1
  start_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !pd_active && !pdn_req && seen_hi && !start_n) |=> (busy && eng_start));

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !eng_done) |=> busy);

  // R2
  single_launch_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !eng_start);

  // R3
  result_load_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && eng_done) |=> (!busy && dout == $past(eng_result)));

  // R3
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(busy && eng_done) |=> $stable(dout));

  // R6
  low_pwr_chk: assert property (@(posedge clk) disable iff (rst)
    low_pwr != busy);

  // R10
  pdn_enter_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && pdn_req) |=> (pd_active && !busy));

  // R9
  pdn_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (pd_active && !pdn_req) |=> (!pd_active && !busy));
endmodule

bind conv_seq conv_seq_chk #(.W(W)) u_chk (.*);

// File: tb/conv_seq_bench.sv
module conv_seq_bench;
  localparam int W    = 18;
  localparam int ACQ  = 6;
  localparam int CONV = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst = 1'b1, start_n = 1'b1, pdn_req = 1'b0;
  logic         eng_done, eng_start, busy, low_pwr, pd_active;
  logic [W-1:0] eng_result, dout;

  conv_seq #(.W(W), .ACQ_CYC(ACQ)) u_conv_seq (
    .clk(clk), .rst(rst), .start_n(start_n), .pdn_req(pdn_req),
    .eng_done(eng_done), .eng_result(eng_result), .eng_start(eng_start),
    .busy(busy), .low_pwr(low_pwr), .pd_active(pd_active), .dout(dout));

  function automatic logic [W-1:0] fval(int i);
    return W'(i * 31337 + 12345);
  endfunction

  // stub engine: fixed-length countdown
  int           s_cnt = 0;
  int           s_k = 0;
  logic [W-1:0] s_res = '0;
  always_ff @(posedge clk) begin
    if (eng_start) begin
      s_cnt <= CONV;
      s_res <= fval(s_k);
      s_k   <= s_k + 1;
    end else if (s_cnt != 0) s_cnt <= s_cnt - 1;
  end
  assign eng_done   = (s_cnt == 1);
  assign eng_result = s_res;

  int n_tests = 0, n_fail = 0;
  int next_k = 0;
  logic [W-1:0] expq[$];

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic expect_conv();
    expq.push_back(fval(next_k));
    next_k++;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 200) begin
      step(1);
      g++;
    end
  endtask

  // monitor / scoreboard
  int   n_starts = 0, n_done = 0, run = 0, gap = 0, last_len = 0, last_gap = 0;
  logic prev_busy = 1'b0;
  always @(negedge clk) begin
    if (eng_start) n_starts++;
    if (busy) begin
      run++;
      if (!prev_busy) last_gap = gap;
      gap = 0;
    end else begin
      gap++;
      if (prev_busy) begin
        last_len = run;
        if (!rst) begin
          n_done++;
          if (expq.size() == 0) check(1'b0, "R3 unexpected result", int'(dout), -1);
          else begin
            logic [W-1:0] e;
            e = expq.pop_front();
            check(dout == e, "R3 result word", int'(dout), int'(e));
          end
        end
      end
      run = 0;
    end
    prev_busy = busy;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int base;
    step(3);
    check(!busy && dout == 0, "R7 reset state", int'(busy), 0);
    check(low_pwr, "R6 low_pwr at reset", int'(low_pwr), 1);
    rst = 1'b0;
    step(30);
    check(n_starts == 0, "R5 no conversion without strobe", n_starts, 0);

    // single conversion
    expect_conv();
    start_n = 1'b0;
    step(1);
    check(busy && eng_start, "R1 busy and launch after edge", int'(busy), 1);
    check(!low_pwr, "R6 low_pwr low while busy", int'(low_pwr), 0);
    start_n = 1'b1;
    step(2);
    check(dout == 0, "R3 dout holds during conversion", int'(dout), 0);
    wait_idle();
    check(last_len == CONV + 1, "R2 convert length", last_len, CONV + 1);
    check(low_pwr, "R6 low_pwr after conversion", int'(low_pwr), 1);
    step(10);
    check(expq.size() == 0, "R3 single result seen", expq.size(), 0);

    // restart attempts ignored
    base = n_starts;
    expect_conv();
    start_n = 1'b0; step(3);
    start_n = 1'b1; step(1);
    start_n = 1'b0; step(1);
    start_n = 1'b1; step(1);
    start_n = 1'b0; step(1);
    start_n = 1'b1;
    wait_idle();
    check(last_len == CONV + 1, "R2 restart ignored length", last_len, CONV + 1);
    check(n_starts == base + 1, "R2 one launch only", n_starts - base, 1);
    step(20);
    check(n_starts == base + 1, "R5 no relaunch after high strobe", n_starts - base, 1);

    // automatic retrigger
    base = n_done;
    repeat (3) expect_conv();
    start_n = 1'b0;
    begin
      int g = 0;
      while (n_done < base + 3 && g < 500) begin step(1); g++; end
    end
    start_n = 1'b1;
    check(last_gap == ACQ, "R4 acquisition gap", last_gap, ACQ);
    base = n_starts;
    step(30);
    check(n_starts == base, "R5 release stops retrigger", n_starts - base, 0);
    check(expq.size() == 0, "R4 three results", expq.size(), 0);

    // power-down recorded mid-conversion
    expect_conv();
    start_n = 1'b0; step(3);
    check(busy, "R8 converting", int'(busy), 1);
    pdn_req = 1'b1; step(1);
    pdn_req = 1'b0; step(1);
    check(busy, "R2 pdn does not abort", int'(busy), 1);
    wait_idle();
    check(last_len == CONV + 1, "R2 length with pdn", last_len, CONV + 1);
    check(pd_active, "R8 deferred power-down", int'(pd_active), 1);
    step(1);
    check(!pd_active, "R9 pd drops after release", int'(pd_active), 0);
    base = n_starts;
    step(20);
    check(n_starts == base, "R9 needs new edge", n_starts - base, 0);
    start_n = 1'b1; step(2);

    // power-down while idle beats a strobe edge
    base = n_starts;
    pdn_req = 1'b1; start_n = 1'b0; step(1);
    check(pd_active && !busy, "R10 pdn wins over edge", int'(pd_active), 1);
    start_n = 1'b1; step(2); start_n = 1'b0; step(2); start_n = 1'b1; step(6);
    check(n_starts == base && pd_active, "R9 edges ignored in pdn", n_starts - base, 0);
    pdn_req = 1'b0; step(2);
    check(!pd_active, "R9 pd cleared", int'(pd_active), 0);
    expect_conv();
    start_n = 1'b0; step(1);
    start_n = 1'b1;
    check(busy, "R9 edge after pdn starts", int'(busy), 1);
    wait_idle();
    step(3);

    // pdn arrives in the completing cycle, strobe held low
    expect_conv();
    start_n = 1'b0;
    begin
      int g = 0;
      while (!eng_done && g < 100) begin step(1); g++; end
    end
    pdn_req = 1'b1;
    step(1);
    check(!busy && pd_active, "R8 same-cycle pdn", int'(pd_active), 1);
    base = n_starts;
    step(15);
    check(n_starts == base && !busy, "R8 no retrigger in pdn", n_starts - base, 0);
    pdn_req = 1'b0; start_n = 1'b1; step(3);
    check(expq.size() == 0, "R8 result latched", expq.size(), 0);

    // reset during conversion
    start_n = 1'b0; step(1);
    next_k++;
    start_n = 1'b1; step(3);
    rst = 1'b1; step(1);
    check(!busy && dout == 0, "R7 reset clears mid-conversion", int'(dout), 0);
    step(1); rst = 1'b0;
    step(20);
    check(dout == 0 && !busy, "R3 stray done ignored", int'(dout), 0);

    expect_conv();
    start_n = 1'b0; step(1);
    start_n = 1'b1;
    wait_idle();
    step(5);
    check(expq.size() == 0, "R1 final conversion", expq.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule